// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A cycle-accurate synchronous static RAM with a small parameterised array split into byte lanes. Every control, address and write-data input is captured on the rising clock edge. The registered request is carried out one edge later, and read data lands in an output register. Data therefore appears on the read port after the second rising edge that follows the request.

A burst begins on either of two start strobes, each of which loads a fresh external address. The processor-side strobe always reads. The controller-side strobe reads or writes, depending on the write controls. After a start, an advance input steps a 2-bit counter through the four words of the aligned block, in linear or interleaved order. Writes can update any subset of byte lanes, or all lanes at once through a global write.

A drive-enable output tells the pad ring when to drive the read bus. It follows output enable, turns off on a write, and survives one deselected cycle before dropping on the second. A registered sleep input freezes the block and keeps its contents.

Top module: `pburst_sram`

## Requirements
- R1: A read request presented before rising edge k updates `rdata` at edge k+1. `rdrive` (with `oe`=1) is first high after edge k+1 and not after edge k.
- R2: An access started by a strobe uses the full `addr`. Its low 2 bits seed the burst counter and its upper bits select the 4-word block.
- R3: An access starts when `sel`=1 together with `strb_proc` or `strb_ctrl`. A `strb_proc` access is always a read and never writes, whatever the write controls. A `strb_ctrl` access writes when any lane is enabled and reads otherwise.
- R4: With `sel`=1 and neither strobe, `adv`=1 makes an access at the next burst address. The upper address bits stay those of the last start, so the burst wraps inside its block.
- R5: With `order_ilv`=0, step n of a burst seeded with s uses low bits (s+n) mod 4, for example 1,2,3,0.
- R6: With `order_ilv`=1, step n uses low bits s XOR n, for example 1,0,3,2.
- R7: In a write, lane i (bits i*LANE_W up to i*LANE_W+LANE_W-1) is written when `bw_en`=1 and `lane_we[i]`=1. With `bw_en`=0 and `wr_all`=0 no lane changes.
- R8: `wr_all`=1 writes every lane, whatever `bw_en` and `lane_we` are.
- R9: `rdrive` = `oe` AND an internal live flag. The flag is set by a completed read and cleared by a completed write.
- R10: After a read, `rdrive` stays high through the first processed deselected cycle (`sel`=0). It drops when a second consecutive deselected cycle is processed. A selected cycle in between restarts the count.
- R11: `sleep` is registered. While the registered value is 1, the request captured with it is ignored, the array and burst state are kept, and `rdrive` is low. The live flag is restored when sleep ends.
- R12: During reset `rdata` is 0 and `rdrive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 1 | Chip select |
| strb_proc | input | 1 | Read-only burst start strobe |
| strb_ctrl | input | 1 | Read/write burst start strobe |
| adv | input | 1 | Step burst counter and access next word |
| order_ilv | input | 1 | 1 interleaved burst order, 0 linear |
| bw_en | input | 1 | Byte-write enable, qualifies `lane_we` |
| lane_we | input | LANES | Per-lane write strobes |
| wr_all | input | 1 | Global write of all lanes |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| oe | input | 1 | Output enable |
| sleep | input | 1 | Standby: ignore requests, hold state |
| rdata | output | LANES*LANE_W | Read pipeline register |
| rdrive | output | 1 | Read bus drive enable |

## Verification
Bursts are written with the controller strobe and read back both word by word and as pipelined bursts. Seeds 0 to 3 are used in both orders, so a linear/interleaved mix-up or a carry into the block bits shows as data from the wrong word. Byte-lane writes use a checkerboard lane mask, strobes without the byte-write enable, and a global write with every lane strobe off, which separates lane gating from global override. The drive-enable tests cover a single deselect against a double deselect, a write after a read, output enable, and a sleep cycle that carries a write, so both timing and freeze behaviour are observed at the ports.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low address bits of burst step "step" from seed "seed"
  function automatic logic [1:0] burst_low(input logic [1:0] seed,
                                           input logic [1:0] step,
                                           input logic       ilv);
    return ilv ? (seed ^ step) : (seed + step);
  endfunction

endpackage

// File: rtl/pbsram_burst_ctr.sv
module pbsram_burst_ctr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cont,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] ea
);
  import pbsram_pkg::*;

  localparam int BLK_W = ADDR_W - 2;

  logic [BLK_W-1:0] base_q, base_d;
  logic [1:0]       seed_q, seed_d;
  logic [1:0]       step_q, step_d, step_n;
  logic             ld_en;

  always_comb begin
    step_n = step_q + 2'd1;
    base_d = base_q;
    seed_d = seed_q;
    step_d = step_q;
    if (start) begin
      base_d = addr_in[ADDR_W-1:2];
      seed_d = addr_in[1:0];
      step_d = 2'd0;
    end else if (cont) begin
      step_d = step_n;
    end
    ld_en = start | cont;
    ea    = start ? addr_in : {base_q, burst_low(seed_q, step_n, ilv)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      seed_q <= '0;
      step_q <= '0;
    end else if (ld_en) begin
      base_q <= base_d;
      seed_q <= seed_d;
      step_q <= step_d;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> (step_q == $past(step_q) + 2'd1)); // R4
  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> $stable(base_q)); // R4
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (step_q == 2'd0)); // R2

endmodule

// File: rtl/pbsram_lane_dec.sv
module pbsram_lane_dec #(
  parameter int LANES = 4
) (
  input  logic             bw_en,
  input  logic [LANES-1:0] lane_we,
  input  logic             wr_all,
  output logic [LANES-1:0] mask
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g] = wr_all | (bw_en & lane_we[g]);
  end

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        we,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_l;

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_l <= '0;
      else if (re) q_l <= mem[addr];
    end

    assign q[g*LANE_W +: LANE_W] = q_l;
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(re && (|we))); // R3

endmodule

// File: rtl/pbsram_drive.sv
module pbsram_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go,
  input  logic wr_go,
  input  logic desel,
  input  logic sleep,
  input  logic oe,
  output logic drive
);

  logic live_q, live_d;
  logic idle_q, idle_d;

  always_comb begin
    live_d = live_q;
    idle_d = idle_q;
    if (sleep) begin
      live_d = live_q;
      idle_d = idle_q;
    end else if (rd_go) begin
      live_d = 1'b1;
      idle_d = 1'b0;
    end else if (wr_go) begin
      live_d = 1'b0;
      idle_d = 1'b0;
    end else if (desel) begin
      if (idle_q) live_d = 1'b0;
      idle_d = 1'b1;
    end else begin
      idle_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      live_q <= live_d;
      idle_q <= idle_d;
    end
  end

  assign drive = oe & live_q & ~sleep;

  AST_READ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !sleep) |=> live_q); // R9
  AST_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !sleep) |=> !live_q); // R9
  AST_DESEL_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    (desel && !sleep && $past(desel && !sleep)) |=> !live_q); // R10
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(live_q)); // R11

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    strb_proc,
  input  logic                    strb_ctrl,
  input  logic                    adv,
  input  logic                    order_ilv,
  input  logic                    bw_en,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    wr_all,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdrive
);
  import pbsram_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // input register stage
  logic             r_sel, r_sp, r_sc, r_adv, r_ilv, r_bwe, r_all, r_sleep;
  logic [LANES-1:0] r_lane;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      r_sel   <= 1'b0;
      r_sp    <= 1'b0;
      r_sc    <= 1'b0;
      r_adv   <= 1'b0;
      r_ilv   <= 1'b0;
      r_bwe   <= 1'b0;
      r_all   <= 1'b0;
      r_sleep <= 1'b0;
      r_lane  <= '0;
    end else begin
      r_sel   <= sel;
      r_sp    <= strb_proc;
      r_sc    <= strb_ctrl;
      r_adv   <= adv;
      r_ilv   <= order_ilv;
      r_bwe   <= bw_en;
      r_all   <= wr_all;
      r_sleep <= sleep;
      r_lane  <= lane_we;
    end
  end

  always_ff @(posedge clk) begin
    r_addr  <= addr;
    r_wdata <= wdata;
  end

  // request decode
  logic             go_start, go_cont;
  logic [LANES-1:0] lane_mask, we_mask;
  logic [ADDR_W-1:0] eff_addr;
  op_e              op;
  logic             rd_go, wr_go;

  pbsram_lane_dec #(.LANES(LANES)) u_lane (
    .bw_en   (r_bwe),
    .lane_we (r_lane),
    .wr_all  (r_all),
    .mask    (lane_mask)
  );

  always_comb begin
    go_start = r_sel & (r_sp | r_sc) & ~r_sleep;
    go_cont  = r_sel & ~r_sp & ~r_sc & r_adv & ~r_sleep;
    op       = OP_NONE;
    if (go_start | go_cont) begin
      op = (~r_sp & (|lane_mask)) ? OP_WRITE : OP_READ;
    end
    rd_go   = (op == OP_READ);
    wr_go   = (op == OP_WRITE);
    we_mask = wr_go ? lane_mask : '0;
  end

  pbsram_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (go_start),
    .cont    (go_cont),
    .ilv     (r_ilv),
    .addr_in (r_addr),
    .ea      (eff_addr)
  );

  pbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (we_mask),
    .re    (rd_go),
    .addr  (eff_addr),
    .wdata (r_wdata),
    .q     (rdata)
  );

  pbsram_drive u_drive (
    .clk   (clk),
    .rst_n (rst_int_n),
    .rd_go (rd_go),
    .wr_go (wr_go),
    .desel (~r_sel),
    .sleep (r_sleep),
    .oe    (oe),
    .drive (rdrive)
  );

  AST_SLEEP_Q_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    r_sleep |=> $stable(rdata)); // R11

endmodule

// File: tb/pburst_sram_test.sv
module pburst_sram_test;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk, rst_n, sel, strb_proc, strb_ctrl, adv, order_ilv;
  logic          bw_en, wr_all, oe, sleep;
  logic [LN-1:0] lane_we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rdrive;

  int n_chk  = 0;
  int n_fail = 0;

  pburst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .strb_proc(strb_proc),
    .strb_ctrl(strb_ctrl), .adv(adv), .order_ilv(order_ilv), .bw_en(bw_en),
    .lane_we(lane_we), .wr_all(wr_all), .addr(addr), .wdata(wdata),
    .oe(oe), .sleep(sleep), .rdata(rdata), .rdrive(rdrive)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // {ilv, start address, expected low bits of steps 0..3}
  localparam int NV = 7;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 6'd9,  8'h6C},   // R5 seed 1: 1,2,3,0
    {1'b1, 6'd9,  8'h4E},   // R6 seed 1: 1,0,3,2
    {1'b0, 6'd22, 8'hB1},   // R5 seed 2: 2,3,0,1
    {1'b1, 6'd22, 8'hB1},   // R6 seed 2: 2,3,0,1
    {1'b1, 6'd39, 8'hE4},   // R6 seed 3: 3,2,1,0
    {1'b0, 6'd39, 8'hC6},   // R5 seed 3: 3,0,1,2
    {1'b1, 6'd44, 8'h1B}    // R6 seed 0: 0,1,2,3
  };

  function automatic logic [DW-1:0] dat(input int e, input int n);
    return {9'(e + 1), 9'(n), 9'(e * 3 + n + 5), 9'h155 ^ 9'(n)};
  endfunction

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [LN-1:0] m);
    logic [DW-1:0] r;
    r = old_v;
    for (int i = 0; i < LN; i++)
      if (m[i]) r[i*LW +: LW] = new_v[i*LW +: LW];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_noop();
    sel = 1'b1; strb_proc = 1'b0; strb_ctrl = 1'b0; adv = 1'b0;
    bw_en = 1'b0; lane_we = '0; wr_all = 1'b0; sleep = 1'b0;
  endtask

  task automatic read_one(input logic [AW-1:0] a, input logic use_ctrl,
                          input logic [DW-1:0] exp, input string tag);
    set_noop();
    if (use_ctrl) strb_ctrl = 1'b1;
    else          strb_proc = 1'b1;
    addr = a;
    tick();
    set_noop();
    tick();
    chk(tag, rdata, exp);
  endtask

  task automatic write_one(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic be, input logic [LN-1:0] lw,
                           input logic all);
    set_noop();
    strb_ctrl = 1'b1; addr = a; wdata = d;
    bw_en = be; lane_we = lw; wr_all = all;
    tick();
    set_noop();
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam logic [DW-1:0] PA = 36'h123456789;
  localparam logic [DW-1:0] PB = 36'hFEDCBA987;
  localparam logic [DW-1:0] PC = 36'h0F0F0F0F0;
  localparam logic [DW-1:0] PD = 36'hA5A5A5A5A;
  localparam logic [DW-1:0] PE = 36'h333333333;

  initial begin
    rst_n = 1'b0; oe = 1'b1; order_ilv = 1'b0; addr = '0; wdata = '0;
    set_noop();
    repeat (3) tick();
    chk("R12 reset rdata", rdata, '0);
    chk("R12 reset rdrive", DW'(rdrive), '0);
    rst_n = 1'b1;
    repeat (3) tick();

    // table of bursts: write with controller strobe, read back
    for (int e = 0; e < NV; e++) begin
      logic          ilv;
      logic [AW-1:0] sa;
      logic [7:0]    seq;
      ilv = VEC[e][14];
      sa  = VEC[e][13:8];
      seq = VEC[e][7:0];
      for (int n = 0; n < 4; n++) begin
        set_noop();
        order_ilv = ilv;
        if (n == 0) begin strb_ctrl = 1'b1; addr = sa; end
        else        adv = 1'b1;
        wr_all = 1'b1;
        wdata  = dat(e, n);
        tick();
      end
      set_noop();
      tick();
      for (int n = 0; n < 4; n++) begin
        read_one({sa[AW-1:2], seq[7-2*n -: 2]}, 1'b0, dat(e, n),
                 ilv ? "R6 R2 interleaved write step" : "R5 R2 linear write step");
      end
      for (int n = 0; n < 5; n++) begin
        set_noop();
        order_ilv = ilv;
        if (n == 0)     begin strb_proc = 1'b1; addr = sa; end
        else if (n < 4) adv = 1'b1;
        tick();
        if (n >= 1) chk(ilv ? "R4 R6 burst read step" : "R4 R5 burst read step",
                        rdata, dat(e, n - 1));
      end
    end
    order_ilv = 1'b0;

    // byte lanes
    write_one(6'd50, PA, 1'b0, 4'b0000, 1'b1);
    read_one(6'd50, 1'b0, PA, "R8 global write");
    write_one(6'd50, PB, 1'b1, 4'b0101, 1'b0);
    read_one(6'd50, 1'b0, lane_merge(PA, PB, 4'b0101), "R7 lanes 0 and 2");
    write_one(6'd50, PC, 1'b0, 4'b1111, 1'b0);
    read_one(6'd50, 1'b0, lane_merge(PA, PB, 4'b0101), "R7 strobes without enable");
    write_one(6'd50, PD, 1'b0, 4'b0000, 1'b1);
    read_one(6'd50, 1'b0, PD, "R8 global overrides lane controls");

    // processor strobe never writes
    set_noop();
    strb_proc = 1'b1; addr = 6'd50; wr_all = 1'b1; bw_en = 1'b1;
    lane_we = 4'b1111; wdata = PE;
    tick();
    set_noop();
    tick();
    chk("R3 proc strobe with write controls reads", rdata, PD);
    read_one(6'd50, 1'b1, PD, "R3 array unchanged, controller strobe read");

    // output enable and write clearing
    chk("R9 drive after read", DW'(rdrive), DW'(1'b1));
    oe = 1'b0;
    #1;
    chk("R9 oe low", DW'(rdrive), '0);
    oe = 1'b1;
    #1;
    chk("R9 oe high", DW'(rdrive), DW'(1'b1));
    write_one(6'd51, PE, 1'b0, 4'b0000, 1'b1);
    chk("R9 write clears drive", DW'(rdrive), '0);

    // latency and double deselect
    set_noop();
    sel = 1'b0;
    repeat (3) tick();
    set_noop();
    strb_proc = 1'b1; addr = 6'd51;
    tick();
    chk("R1 no drive after first edge", DW'(rdrive), '0);
    set_noop();
    tick();
    chk("R1 drive after second edge", DW'(rdrive), DW'(1'b1));
    chk("R1 data after second edge", rdata, PE);
    sel = 1'b0;
    tick();
    chk("R10 deselect registered", DW'(rdrive), DW'(1'b1));
    tick();
    chk("R10 first deselect keeps drive", DW'(rdrive), DW'(1'b1));
    tick();
    chk("R10 second deselect drops drive", DW'(rdrive), '0);

    read_one(6'd50, 1'b0, PD, "R10 read before single deselect");
    sel = 1'b0;
    tick();
    set_noop();
    tick();
    tick();
    chk("R10 single deselect keeps drive", DW'(rdrive), DW'(1'b1));

    // sleep
    set_noop();
    sleep = 1'b1; strb_ctrl = 1'b1; wr_all = 1'b1; addr = 6'd50; wdata = PE;
    tick();
    chk("R11 drive off in sleep", DW'(rdrive), '0);
    set_noop();
    tick();
    chk("R11 drive restored after sleep", DW'(rdrive), DW'(1'b1));
    read_one(6'd50, 1'b0, PD, "R11 write during sleep ignored");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule